// File: doc/BRIEF.md
# Edge-Triggered Window Fetch Engine

This block belongs to one port of a management controller for pluggable modules. It watches one of three status inputs from the port for a chosen edge. When that edge arrives while the engine is armed, it reads a window of up to 32 bytes from one of two downstream devices. The bytes go into a local buffer, and the engine reports success on an active-low interrupt and on a per-port flag. After a success the engine stays quiet until software writes the re-arm strobe. A fetch that the device refuses leaves the engine armed for the next edge.

The engine shares the downstream request stream with a periodic fetch engine and gets the grant first. Host reads are resolved by comparing the address with the window the engine holds. On a hit, the engine's byte is returned even when the periodic engine also has that address. On a miss, the periodic engine's hit and data pass through unchanged.

The downstream request is a valid/ready stream. While `dn_req_valid` is high, the request fields stay stable until `dn_req_ready` is seen. The response is a valid/ready stream of one byte per beat, and a beat counts only when `dn_rsp_valid` and `dn_rsp_ready` are both high. The bus master is assumed to serve one request at a time. Its response beats belong to the last request it accepted.

Top module: `evpf_engine`

## Requirements
- R1: After reset the engine is disarmed. `host_int_n`=1, `port_flag`=0 and `gate_serving`=0. It drives no request of its own, and `dn_rsp_ready`=0.
- R2: `cfg_in_sel` picks the trigger input: 0 = `status_in[0]`, 1 = `status_in[1]`, 2 = `status_in[2]`, 3 = none. `cfg_fall`=0 selects rising edges and `cfg_fall`=1 selects falling edges. The input passes through two synchronizer flops. In the armed state, a qualifying change that is sampled at clock edge n raises the engine's request after clock edge n+2.
- R3: The engine captures `cfg_offset`, `cfg_len_m1` (window length minus one) and `cfg_dev` when the trigger is taken. It shows them on the request with `dn_req_evt`=1, holding the request stable until `dn_req_ready`.
- R4: Whenever the engine requests, it owns the request stream and `per_req_ready`=0. Otherwise the periodic request passes through with `dn_req_evt`=0, and `per_req_ready` follows `dn_req_ready`.
- R5: `dn_rsp_ready` is high only after the engine's request was accepted and until the fetch ends. Accepted beats are stored in window order, and the fetch succeeds on beat `cfg_len_m1`+1.
- R6: In the cycle after the last beat, `gate_serving`=1, `host_int_n`=0 and `port_flag`=1.
- R7: A beat with `dn_rsp_nack`=1 ends the fetch. The engine returns to armed with no interrupt and `gate_serving`=0, and the next qualifying edge starts a new fetch without a re-arm.
- R8: After a success, the interrupt, the flag and the gate stay set and edges are ignored until `rearm` is sampled high. One cycle later all three are cleared and the engine is armed.
- R9: Edges are ignored while the engine is disarmed, requesting or receiving, and whenever `cfg_in_sel`=3.
- R10: While `gate_serving`=1, a host lookup hits when `host_dev` equals the captured device and `host_addr` lies in [offset, offset+length). The bounds are compared without wrap above 255. On a hit the engine returns its stored byte `host_addr`-offset and takes precedence over `per_hit`.
- R11: When the engine does not hit, `host_hit` equals `per_hit` and `host_data` equals `per_data`.
- R12: `rearm` arms the engine from the reset state and from the success state. It is ignored while the engine is requesting or receiving. In the armed state a trigger is taken even if `rearm` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_sel | input | 2 | Trigger input select (3 = none) |
| cfg_fall | input | 1 | 1 = falling edge, 0 = rising edge |
| cfg_offset | input | 8 | First register address of the window |
| cfg_len_m1 | input | 5 | Window length minus one |
| cfg_dev | input | 1 | Downstream device select |
| rearm | input | 1 | Re-arm write strobe |
| status_in | input | 3 | Port status inputs, asynchronous |
| per_req_valid | input | 1 | Periodic engine request valid |
| per_req_ready | output | 1 | Periodic engine request accepted |
| per_req_dev | input | 1 | Periodic request device |
| per_req_offset | input | 8 | Periodic request offset |
| per_req_len_m1 | input | 5 | Periodic request length minus one |
| dn_req_valid | output | 1 | Merged request valid |
| dn_req_ready | input | 1 | Bus master accepts request |
| dn_req_dev | output | 1 | Merged request device |
| dn_req_offset | output | 8 | Merged request offset |
| dn_req_len_m1 | output | 5 | Merged request length minus one |
| dn_req_evt | output | 1 | 1 when the request is this engine's |
| dn_rsp_valid | input | 1 | Response beat valid |
| dn_rsp_ready | output | 1 | Engine accepts response beats |
| dn_rsp_data | input | 8 | Response byte |
| dn_rsp_nack | input | 1 | Beat reports a refused transfer |
| host_addr | input | 8 | Host lookup address |
| host_dev | input | 1 | Host lookup device |
| per_hit | input | 1 | Periodic engine lookup hit |
| per_data | input | 8 | Periodic engine lookup byte |
| host_hit | output | 1 | Merged lookup hit |
| host_data | output | 8 | Merged lookup byte |
| gate_serving | output | 1 | Engine buffer holds a valid window |
| host_int_n | output | 1 | Active-low interrupt |
| port_flag | output | 1 | Port's aggregated interrupt flag |

## Verification
The trigger path is driven in three ways:
- edges on the selected input in the chosen direction;
- edges on the other inputs or in the other direction;
- edges that arrive while the engine is disarmed, fetching or already successful.

Together these separate a correct select and polarity decode from a wrong one, and show which states ignore edges. Fetches run under these conditions:
- request back-pressure while a periodic request is pending;
- response streams that contain idle gaps;
- a refusal in the middle of a window;
- a full 32-byte window.

They expose errors in priority, in beat counting and in the retry path. Host lookups sweep across and past both window edges, for both devices, with the periodic engine always reporting a hit. This tells the engine's precedence apart from plain pass-through.

// File: rtl/evpf_pkg.sv
package evpf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_REQ   = 3'd2,
    ST_RECV  = 3'd3,
    ST_DONE  = 3'd4
  } evpf_state_t;
endpackage

// File: rtl/evpf_sync_edge.sv
module evpf_sync_edge #(
  parameter int N_IN   = 3,
  parameter int STAGES = 2,
  localparam int SEL_W = $clog2(N_IN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  din,
  input  logic [SEL_W-1:0] sel,
  input  logic             fall,
  output logic             evt
);
  logic [N_IN-1:0] cur, prev;

  for (genvar i = 0; i < N_IN; i++) begin : g_chain
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din[i]};
    end
    assign cur[i]  = chain[STAGES-1];
    assign prev[i] = chain[STAGES];
  end

  always_comb begin
    evt = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel == SEL_W'(i))
        evt = fall ? (prev[i] & ~cur[i]) : (cur[i] & ~prev[i]);
    end
  end
endmodule

// File: rtl/evpf_buf.sv
module evpf_buf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/evpf_ctrl.sv
module evpf_ctrl
  import evpf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              rearm,
  input  logic [ADDR_W-1:0] cfg_offset,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_dev,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  output logic              req_valid,
  output logic              rsp_ready,
  output logic              serving,
  output logic              wr_en,
  output logic [LEN_W-1:0]  wr_idx,
  output logic [ADDR_W-1:0] off_q,
  output logic [LEN_W-1:0]  len_m1_q,
  output logic              dev_q
);
  evpf_state_t state, state_n;
  logic [LEN_W-1:0] cnt;
  logic beat;

  assign beat = (state == ST_RECV) && rsp_valid;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (rearm) state_n = ST_ARMED;
      ST_ARMED: if (trig) state_n = ST_REQ;
      ST_REQ:   if (req_ready) state_n = ST_RECV;
      ST_RECV:  if (beat) begin
                  if (rsp_nack)             state_n = ST_ARMED;
                  else if (cnt == len_m1_q) state_n = ST_DONE;
                end
      ST_DONE:  if (rearm) state_n = ST_ARMED;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      off_q    <= '0;
      len_m1_q <= '0;
      dev_q    <= 1'b0;
    end else begin
      state <= state_n;
      if (state == ST_ARMED && trig) begin
        off_q    <= cfg_offset;
        len_m1_q <= cfg_len_m1;
        dev_q    <= cfg_dev;
      end
      if (state == ST_REQ)             cnt <= '0;
      else if (beat && !rsp_nack)      cnt <= cnt + 1'b1;
    end
  end

  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_RECV);
  assign serving   = (state == ST_DONE);
  assign wr_en     = beat && !rsp_nack;
  assign wr_idx    = cnt;
endmodule

// File: rtl/evpf_engine.sv
module evpf_engine #(
  parameter int N_IN   = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int STAGES = 2,
  localparam int SEL_W = $clog2(N_IN + 1),
  localparam int LEN_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_in_sel,
  input  logic              cfg_fall,
  input  logic [ADDR_W-1:0] cfg_offset,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_dev,
  input  logic              rearm,
  input  logic [N_IN-1:0]   status_in,
  input  logic              per_req_valid,
  output logic              per_req_ready,
  input  logic              per_req_dev,
  input  logic [ADDR_W-1:0] per_req_offset,
  input  logic [LEN_W-1:0]  per_req_len_m1,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_dev,
  output logic [ADDR_W-1:0] dn_req_offset,
  output logic [LEN_W-1:0]  dn_req_len_m1,
  output logic              dn_req_evt,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_data,
  input  logic              dn_rsp_nack,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_dev,
  input  logic              per_hit,
  input  logic [DATA_W-1:0] per_data,
  output logic              host_hit,
  output logic [DATA_W-1:0] host_data,
  output logic              gate_serving,
  output logic              host_int_n,
  output logic              port_flag
);
  logic              trig, evt_req, serving, wr_en, dev_q;
  logic [LEN_W-1:0]  wr_idx, len_m1_q;
  logic [ADDR_W-1:0] off_q;
  logic [DATA_W-1:0] buf_data;
  logic [ADDR_W:0]   diff;
  logic              in_win, evt_hit;

  evpf_sync_edge #(.N_IN(N_IN), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(status_in),
    .sel(cfg_in_sel), .fall(cfg_fall), .evt(trig)
  );

  evpf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rearm(rearm),
    .cfg_offset(cfg_offset), .cfg_len_m1(cfg_len_m1), .cfg_dev(cfg_dev),
    .req_ready(dn_req_ready), .rsp_valid(dn_rsp_valid), .rsp_nack(dn_rsp_nack),
    .req_valid(evt_req), .rsp_ready(dn_rsp_ready), .serving(serving),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .off_q(off_q), .len_m1_q(len_m1_q), .dev_q(dev_q)
  );

  evpf_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(dn_rsp_data),
    .rd_idx(diff[LEN_W-1:0]), .rd_data(buf_data)
  );

  // fixed priority: own request first
  assign dn_req_valid  = evt_req | per_req_valid;
  assign dn_req_evt    = evt_req;
  assign per_req_ready = dn_req_ready & ~evt_req;
  assign dn_req_dev    = evt_req ? dev_q    : per_req_dev;
  assign dn_req_offset = evt_req ? off_q    : per_req_offset;
  assign dn_req_len_m1 = evt_req ? len_m1_q : per_req_len_m1;

  // window lookup without wrap
  assign diff    = {1'b0, host_addr} - {1'b0, off_q};
  assign in_win  = (host_addr >= off_q) && (diff <= (ADDR_W+1)'(len_m1_q));
  assign evt_hit = serving && (host_dev == dev_q) && in_win;

  assign host_hit  = evt_hit | per_hit;
  assign host_data = evt_hit ? buf_data : per_data;

  assign gate_serving = serving;
  assign host_int_n   = ~serving;
  assign port_flag    = serving;
endmodule

// File: rtl/evpf_chk.sv
module evpf_chk (
  input logic clk,
  input logic rst_n,
  input logic rearm,
  input logic per_req_ready,
  input logic dn_req_valid,
  input logic dn_req_ready,
  input logic dn_req_evt,
  input logic [7:0] dn_req_offset,
  input logic dn_rsp_valid,
  input logic dn_rsp_ready,
  input logic dn_rsp_nack,
  input logic per_hit,
  input logic host_hit,
  input logic gate_serving,
  input logic host_int_n
);
  // R4
  evt_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && dn_req_evt) |-> !per_req_ready);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && dn_req_evt && !dn_req_ready) |=>
      (dn_req_valid && dn_req_evt && $stable(dn_req_offset)));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_int_n |-> gate_serving);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_int_n && !rearm) |=> !host_int_n);

  // R5
  rsp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_ready |-> (!gate_serving && !(dn_req_valid && dn_req_evt)));

  // R7
  nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rsp_valid && dn_rsp_ready && dn_rsp_nack) |=> (host_int_n && !gate_serving));

  // R10
  hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_hit && !per_hit) |-> gate_serving);
endmodule

bind evpf_engine evpf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rearm(rearm),
  .per_req_ready(per_req_ready), .dn_req_valid(dn_req_valid),
  .dn_req_ready(dn_req_ready), .dn_req_evt(dn_req_evt),
  .dn_req_offset(dn_req_offset), .dn_rsp_valid(dn_rsp_valid),
  .dn_rsp_ready(dn_rsp_ready), .dn_rsp_nack(dn_rsp_nack),
  .per_hit(per_hit), .host_hit(host_hit),
  .gate_serving(gate_serving), .host_int_n(host_int_n)
);

// File: tb/sim_evpf_engine.sv
`timescale 1ns/1ps
module sim_evpf_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] cfg_in_sel = 2'd0;
  logic       cfg_fall = 1'b0;
  logic [7:0] cfg_offset = 8'd0;
  logic [4:0] cfg_len_m1 = 5'd0;
  logic       cfg_dev = 1'b0;
  logic       rearm = 1'b0;
  logic [2:0] status_in = 3'b000;
  logic       per_req_valid = 1'b0, per_req_dev = 1'b0;
  logic [7:0] per_req_offset = 8'h40;
  logic [4:0] per_req_len_m1 = 5'd7;
  logic       dn_req_ready = 1'b0;
  logic       dn_rsp_valid = 1'b0, dn_rsp_nack = 1'b0;
  logic [7:0] dn_rsp_data = 8'h11;
  logic [7:0] host_addr = 8'd0;
  logic       host_dev = 1'b0, per_hit = 1'b0;
  logic [7:0] per_data = 8'hEE;
  logic per_req_ready, dn_req_valid, dn_req_dev, dn_req_evt, dn_rsp_ready;
  logic [7:0] dn_req_offset, host_data;
  logic [4:0] dn_req_len_m1;
  logic host_hit, gate_serving, host_int_n, port_flag;

  evpf_engine u0 (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  // reference model state
  int mstate = 0, mcnt = 0, moff = 0, mlen = 1, mdev = 0;
  int mbuf [32];
  logic [2:0] hist [$];

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit ereq, ehit, serv;
    int edata;
    ereq = (mstate == 2);
    serv = (mstate == 4);
    chk("R6 R8 R12 host_int_n", int'(host_int_n), serv ? 0 : 1);
    chk("R6 R8 port_flag", int'(port_flag), serv ? 1 : 0);
    chk("R6 R7 gate_serving", int'(gate_serving), serv ? 1 : 0);
    chk("R2 R9 R4 dn_req_valid", int'(dn_req_valid), (ereq || per_req_valid) ? 1 : 0);
    chk("R4 dn_req_evt", int'(dn_req_evt), ereq ? 1 : 0);
    chk("R4 per_req_ready", int'(per_req_ready), (dn_req_ready && !ereq) ? 1 : 0);
    chk("R5 dn_rsp_ready", int'(dn_rsp_ready), (mstate == 3) ? 1 : 0);
    if (dn_req_valid) begin
      chk("R3 dn_req_offset", int'(dn_req_offset), ereq ? moff : int'(per_req_offset));
      chk("R3 dn_req_len_m1", int'(dn_req_len_m1), ereq ? mlen - 1 : int'(per_req_len_m1));
      chk("R3 dn_req_dev", int'(dn_req_dev), ereq ? mdev : int'(per_req_dev));
    end
    ehit = serv && (int'(host_dev) == mdev) && (int'(host_addr) >= moff)
           && (int'(host_addr) < moff + mlen);
    edata = ehit ? mbuf[int'(host_addr) - moff] : int'(per_data);
    chk("R10 R11 host_hit", int'(host_hit), (ehit || per_hit) ? 1 : 0);
    if (host_hit) chk("R5 R10 R11 host_data", int'(host_data), edata);
  endtask

  task automatic model_step();
    bit ev, c, p;
    ev = 1'b0;
    if (cfg_in_sel != 2'd3) begin
      c = hist[hist.size()-2][cfg_in_sel];
      p = hist[hist.size()-3][cfg_in_sel];
      ev = cfg_fall ? (!c && p) : (c && !p);
    end
    case (mstate)
      0: if (rearm) mstate = 1;
      1: if (ev) begin
           moff = int'(cfg_offset); mlen = int'(cfg_len_m1) + 1;
           mdev = int'(cfg_dev); mstate = 2;
         end
      2: if (dn_req_ready) begin mstate = 3; mcnt = 0; end
      3: if (dn_rsp_valid) begin
           if (dn_rsp_nack) mstate = 1;
           else begin
             mbuf[mcnt] = int'(dn_rsp_data);
             if (mcnt == mlen - 1) mstate = 4;
             else mcnt++;
           end
         end
      4: if (rearm) mstate = 1;
      default: mstate = 0;
    endcase
    hist.push_back(status_in);
    if (hist.size() > 8) void'(hist.pop_front());
  endtask

  task automatic cycle();
    #1;
    compare();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    dn_rsp_data = dn_rsp_data + 8'd29;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic sweep(int lo, int hi, bit dev);
    host_dev = dev;
    for (int a = lo; a <= hi; a++) begin
      host_addr = 8'(a);
      cycle();
    end
  endtask

  initial begin
    repeat (3) hist.push_back(3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    chk("R1 host_int_n", int'(host_int_n), 1);
    chk("R1 port_flag", int'(port_flag), 0);
    chk("R1 gate_serving", int'(gate_serving), 0);
    chk("R1 dn_req_valid", int'(dn_req_valid), 0);
    chk("R1 dn_rsp_ready", int'(dn_rsp_ready), 0);
    step(2);

    // R9: edges while disarmed ignored
    cfg_offset = 8'h10; cfg_len_m1 = 5'd3; dn_rsp_valid = 1'b1;
    status_in = 3'b011; step(6);
    status_in = 3'b000; step(5);
    // R12: arm from reset state
    rearm = 1'b1; step(1); rearm = 1'b0; step(2);
    // R2: other input and wrong polarity ignored
    status_in = 3'b010; step(5);
    status_in = 3'b000; step(5);
    // R2 R4: selected rising edge, periodic request pending and held off
    per_req_valid = 1'b1;
    status_in = 3'b001; step(8);
    dn_req_ready = 1'b1; step(1);
    dn_rsp_valid = 1'b0; step(2); dn_rsp_valid = 1'b1; step(8);
    // R8: edges after success ignored
    status_in = 3'b000; step(4); status_in = 3'b001; step(5);
    // R10 R11: lookup with periodic always hitting
    per_hit = 1'b1;
    sweep(12, 22, 1'b0);
    sweep(14, 20, 1'b1);
    per_hit = 1'b0;
    sweep(15, 20, 1'b0);
    rearm = 1'b1; step(1); rearm = 1'b0; step(3);

    // R7: falling edge on input 2, refused mid-window, then retry
    cfg_in_sel = 2'd2; cfg_fall = 1'b1; cfg_offset = 8'hF0; cfg_len_m1 = 5'd31;
    cfg_dev = 1'b1;
    status_in = 3'b101; step(6);
    status_in = 3'b001; step(10);
    dn_rsp_nack = 1'b1; step(1); dn_rsp_nack = 1'b0; step(4);
    status_in = 3'b101; step(4);
    status_in = 3'b001; step(12);
    // R9: toggles during fetch ignored
    status_in = 3'b101; step(3); status_in = 3'b001; step(40);
    per_hit = 1'b1;
    sweep(232, 255, 1'b1);
    sweep(0, 3, 1'b1);
    per_hit = 1'b0;

    // R12: rearm then trigger with rearm held, rearm during request ignored
    rearm = 1'b1; step(1); rearm = 1'b0; step(2);
    cfg_in_sel = 2'd3; status_in = 3'b111; step(5); status_in = 3'b000; step(5);
    cfg_in_sel = 2'd1; cfg_fall = 1'b0; cfg_offset = 8'h02; cfg_len_m1 = 5'd0;
    cfg_dev = 1'b0; dn_req_ready = 1'b0;
    status_in = 3'b010; rearm = 1'b1; step(6);
    step(2); rearm = 1'b0;
    dn_req_ready = 1'b1; step(4);
    per_hit = 1'b1; sweep(0, 4, 1'b0); per_hit = 1'b0;
    rearm = 1'b1; step(1); rearm = 1'b0; step(3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule